// File: doc/BRIEF.md
# Per-Processor Local Interrupt Router

This block sits beside one virtual processor and steers its seven local interrupt sources onto the processor's interrupt input pins or onto a single non-maskable line. The sources are the watchdog, the count/compare match, the CPU timer, the performance counter, two software interrupts and the debug channel. The block samples each source level into a pending vector. A per-source enable (mask) vector and one routing entry per source then decide which output is raised. The routing entries sit in address order with the debug channel moved in right after the timer, so the routing order differs from the pending and mask bit order.

Software reaches the block through a small 32-bit register port. A request is offered with `bus_req_valid`. `bus_req_ready` is tied high, so the port never applies back-pressure and takes a request on every clock edge where valid is high. A write takes effect on that edge and returns no response. A read returns its data with `bus_rsp_valid` one edge later. The response channel has no ready signal, so the requester must accept each response in the cycle it appears. A read-only control word reports, from parameters, which sources may be rerouted and whether external-controller mode is fixed on.

Top module: `lirq_router`

## Requirements
- R1: After reset, all pin outputs and the NMI output are low, and the enable vector and every routing entry read as zero.
- R2: Pending is read at offset 0x004. Its bit order is 0 watchdog, 1 compare, 2 timer, 3 performance counter, 4 software 0, 5 software 1, 6 debug channel. Each bit follows its source level one clock edge after the source changes.
- R3: The enable vector uses the same bit order and is read at 0x008, where a 1 means the source is enabled. Writing at 0x010 sets every bit written as 1. Writing at 0x00C clears every bit written as 1. Bits written as 0 are left unchanged.
- R4: Routing entries sit at 0x040 + 4*slot. The slots are watchdog 0, compare 1, timer 2, debug channel 3, performance counter 4, software 0 at 5 and software 1 at 6.
- R5: In a routing entry, bit 31 selects pin routing, bit 30 selects NMI routing and bits 5:0 hold the pin number. All other bits read back as zero.
- R6: A pin output is high when at least one source is pending and enabled, has bit 31 set in its entry and names that pin. Several sources may share one pin. An entry with bit 31 clear drives no pin. Outputs update one clock edge after the pending, enable or routing state changes.
- R7: The NMI output is high when at least one pending, enabled source has bit 30 set. When both bits 31 and 30 are set, the source goes to NMI only and drives no pin.
- R8: A pin number at or above NUM_PINS drives no output.
- R9: The control word at 0x000 is read-only. Bit 4 reports the debug channel as routable, bit 3 the software interrupts, bit 2 the performance counter, bit 1 the timer and bit 0 external-controller mode. With default parameters it reads 0x0000001E. Writes to it change nothing.
- R10: `bus_req_ready` is always high. A read is answered with `bus_rsp_valid` high for exactly one cycle, one edge after the read is accepted. A write produces no response. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 7 | Local source levels, pending bit order |
| bus_req_valid | input | 1 | Register request offered |
| bus_req_ready | output | 1 | Request accepted (always high) |
| bus_req_we | input | 1 | 1 = write, 0 = read |
| bus_req_addr | input | ADDR_W | Byte offset of the register |
| bus_req_wdata | input | 32 | Write data |
| bus_rsp_valid | output | 1 | Read data valid |
| bus_rsp_data | output | 32 | Read data |
| irq_pin_o | output | NUM_PINS | Processor interrupt pins |
| irq_nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The bench counts latency from the edge that captures a stimulus. A source change reaches the pending register on the first edge and the outputs on the second. A register write reaches the outputs one edge after it is accepted, and read data appears one edge after the read is taken. All inputs are driven on falling edges, and each result is sampled on the falling edge that follows the edge on which it is due. The bench therefore never samples while a value is changing.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int NSRC   = 7;
  localparam int PIN_W  = 6;
  localparam int DATA_W = 32;

  // Pending / enable bit order (behavioural: software decodes it).
  typedef enum logic [2:0] {
    SRC_WDOG = 3'd0,
    SRC_CMP  = 3'd1,
    SRC_TMR  = 3'd2,
    SRC_PERF = 3'd3,
    SRC_SW0  = 3'd4,
    SRC_SW1  = 3'd5,
    SRC_DBG  = 3'd6
  } src_e;

  typedef struct packed {
    logic             to_pin;
    logic             to_nmi;
    logic [PIN_W-1:0] pin;
  } route_t;

  localparam logic [11:0] OFS_CTL  = 12'h000;
  localparam logic [11:0] OFS_PEND = 12'h004;
  localparam logic [11:0] OFS_EN   = 12'h008;
  localparam logic [11:0] OFS_ECLR = 12'h00C;
  localparam logic [11:0] OFS_ESET = 12'h010;
  localparam logic [11:0] OFS_MAP  = 12'h040;

  // Routing slot of a source: the debug channel moves up behind the timer.
  function automatic int unsigned route_slot(input int unsigned s);
    if (s <= 2) return s;
    if (s == 6) return 3;
    return s + 1;
  endfunction

endpackage

// File: rtl/lirq_regbus.sv
module lirq_regbus
  import lirq_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] CTL_VALUE = 32'h0000_001E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NSRC-1:0]   pend,
  output logic [NSRC-1:0]   enable,
  output route_t            route_by_src [NSRC],
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_ECLR = ADDR_W'(OFS_ECLR);
  localparam logic [ADDR_W-1:0] A_ESET = ADDR_W'(OFS_ESET);
  localparam logic [ADDR_W-1:0] A_MAP  = ADDR_W'(OFS_MAP);
  localparam logic [ADDR_W-1:0] A_MEND = ADDR_W'(OFS_MAP + 12'(4 * NSRC));

  route_t slot_q [NSRC];
  logic   wr, rd, in_map;
  logic [ADDR_W-1:0] map_off;
  logic [2:0]        slot;

  assign wr      = req_valid &&  req_we;
  assign rd      = req_valid && !req_we;
  assign in_map  = (req_addr >= A_MAP) && (req_addr < A_MEND) && (req_addr[1:0] == 2'b00);
  assign map_off = req_addr - A_MAP;
  assign slot    = map_off[4:2];

  // Enable vector: write-one-to-set / write-one-to-clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
    end else if (wr && req_addr == A_ESET) begin
      enable <= enable | req_wdata[NSRC-1:0];
    end else if (wr && req_addr == A_ECLR) begin
      enable <= enable & ~req_wdata[NSRC-1:0];
    end
  end

  // Routing entries, stored in slot order.
  for (genvar k = 0; k < NSRC; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[k] <= '0;
      end else if (wr && in_map && slot == 3'(k)) begin
        slot_q[k].to_pin <= req_wdata[31];
        slot_q[k].to_nmi <= req_wdata[30];
        slot_q[k].pin    <= req_wdata[PIN_W-1:0];
      end
    end
  end

  // Present routing in source order.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign route_by_src[s] = slot_q[route_slot(s)];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (in_map) begin
      for (int k = 0; k < NSRC; k++) begin
        if (slot == 3'(k)) begin
          rd_mux = {slot_q[k].to_pin, slot_q[k].to_nmi,
                    {(DATA_W-2-PIN_W){1'b0}}, slot_q[k].pin};
        end
      end
    end else begin
      case (req_addr)
        A_CTL:   rd_mux = CTL_VALUE;
        A_PEND:  rd_mux = {{(DATA_W-NSRC){1'b0}}, pend};
        A_EN:    rd_mux = {{(DATA_W-NSRC){1'b0}}, enable};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= rd ? rd_mux : rsp_data;
    end
  end

  // R3: set and clear writes act only on the bits written as one
  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_ESET) |=> ((enable & $past(req_wdata[NSRC-1:0])) == $past(req_wdata[NSRC-1:0])));
  a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_ECLR) |=> ((enable & $past(req_wdata[NSRC-1:0])) == '0));
  // R10: a response only follows an accepted read
  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd));
  // R9: control word reads its fixed value
  a_r9_ctl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == A_CTL) |=> (rsp_data == CTL_VALUE));

endmodule

// File: rtl/lirq_lane.sv
module lirq_lane
  import lirq_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                active,
  input  route_t              route,
  output logic [NUM_PINS-1:0] pin_req,
  output logic                nmi_req
);

  logic pin_mode;
  assign nmi_req  = active && route.to_nmi;
  assign pin_mode = active && route.to_pin && !route.to_nmi;

  // Pin numbers at or above NUM_PINS never match any output.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pin_req[p] = pin_mode && (route.pin == PIN_W'(p));
  end

endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int NUM_PINS      = 6,
  parameter int ADDR_W        = 8,
  parameter bit DBG_ROUTABLE  = 1'b1,
  parameter bit SW_ROUTABLE   = 1'b1,
  parameter bit PERF_ROUTABLE = 1'b1,
  parameter bit TMR_ROUTABLE  = 1'b1,
  parameter bit EXT_CTRL_MODE = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [6:0]          src_i,
  input  logic                bus_req_valid,
  output logic                bus_req_ready,
  input  logic                bus_req_we,
  input  logic [ADDR_W-1:0]   bus_req_addr,
  input  logic [31:0]         bus_req_wdata,
  output logic                bus_rsp_valid,
  output logic [31:0]         bus_rsp_data,
  output logic [NUM_PINS-1:0] irq_pin_o,
  output logic                irq_nmi_o
);

  localparam logic [31:0] CTL_VALUE = {27'd0, DBG_ROUTABLE, SW_ROUTABLE,
                                       PERF_ROUTABLE, TMR_ROUTABLE, EXT_CTRL_MODE};

  logic [NSRC-1:0]     pend_q;
  logic [NSRC-1:0]     enable;
  route_t              route_by_src [NSRC];
  logic [NUM_PINS-1:0] lane_pins [NSRC];
  logic [NSRC-1:0]     lane_nmi;
  logic [NUM_PINS-1:0] pins_d;
  logic                nmi_d;

  assign bus_req_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= src_i;
  end

  lirq_regbus #(.ADDR_W(ADDR_W), .CTL_VALUE(CTL_VALUE)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (bus_req_valid),
    .req_we       (bus_req_we),
    .req_addr     (bus_req_addr),
    .req_wdata    (bus_req_wdata),
    .pend         (pend_q),
    .enable       (enable),
    .route_by_src (route_by_src),
    .rsp_valid    (bus_rsp_valid),
    .rsp_data     (bus_rsp_data)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_lane
    lirq_lane #(.NUM_PINS(NUM_PINS)) u_lane (
      .active  (pend_q[s] && enable[s]),
      .route   (route_by_src[s]),
      .pin_req (lane_pins[s]),
      .nmi_req (lane_nmi[s])
    );
  end

  always_comb begin
    pins_d = '0;
    for (int s = 0; s < NSRC; s++) pins_d |= lane_pins[s];
    nmi_d = |lane_nmi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pin_o <= '0;
      irq_nmi_o <= 1'b0;
    end else begin
      irq_pin_o <= pins_d;
      irq_nmi_o <= nmi_d;
    end
  end

  // R6: a raised pin needs a pending, enabled source one edge earlier
  a_r6_pin_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_pin_o) |-> $past(|(pend_q & enable)));
  // R7: NMI needs a pending, enabled source one edge earlier
  a_r7_nmi_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_nmi_o |-> $past(|(pend_q & enable)));
  // R10: the port never back-pressures
  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_ready);

endmodule

// File: tb/lirq_router_tb.sv
module lirq_router_tb;

  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  src = '0;
  logic        rv = 1'b0, we = 1'b0;
  logic        ready;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_v;
  logic [31:0] rsp_d;
  logic [NP-1:0] pins;
  logic        nmi;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_req_valid(rv), .bus_req_ready(ready), .bus_req_we(we),
    .bus_req_addr(addr), .bus_req_wdata(wdata),
    .bus_rsp_valid(rsp_v), .bus_rsp_data(rsp_d),
    .irq_pin_o(pins), .irq_nmi_o(nmi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); rv = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); rv = 0; we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); rv = 1; we = 0; addr = a;
    @(negedge clk); rv = 0;
    chk({req, " rsp_valid"}, {31'd0, rsp_v}, 32'd1);
    chk(req, rsp_d, exp);
    @(negedge clk);
    chk({req, " single response"}, {31'd0, rsp_v}, 32'd0);
  endtask

  // Let outputs settle: two edges after the last change.
  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // {src[20:14], enable[13:7], pins[6:1], nmi[0]}
  localparam logic [20:0] VEC [10] = '{
    {7'h7F, 7'h7F, 6'h1F, 1'b1},
    {7'h01, 7'h7F, 6'h01, 1'b0},
    {7'h08, 7'h7F, 6'h08, 1'b0},
    {7'h40, 7'h7F, 6'h00, 1'b1},
    {7'h30, 7'h7F, 6'h10, 1'b0},
    {7'h7F, 7'h00, 6'h00, 1'b0},
    {7'h7F, 7'h40, 6'h00, 1'b1},
    {7'h14, 7'h10, 6'h10, 1'b0},
    {7'h04, 7'h04, 6'h04, 1'b0},
    {7'h00, 7'h7F, 6'h00, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pins", {26'd0, pins}, 32'd0);
    chk("R1 nmi", {31'd0, nmi}, 32'd0);
    chk("R10 ready", {31'd0, ready}, 32'd1);
    rd_chk("R1 enable", 8'h08, 32'd0);
    rd_chk("R1 map", 8'h4C, 32'd0);
    // R9 control word, write ignored
    rd_chk("R9 ctl", 8'h00, 32'h0000_001E);
    wr(8'h00, 32'h0000_0000);
    rd_chk("R9 ctl after write", 8'h00, 32'h0000_001E);
    // R10 unmapped
    rd_chk("R10 unmapped", 8'h20, 32'd0);
    // R3 set/clear
    wr(8'h10, 32'h7F);
    wr(8'h0C, 32'h00);
    rd_chk("R3 clear zeros", 8'h08, 32'h7F);
    wr(8'h0C, 32'h05);
    rd_chk("R3 clear", 8'h08, 32'h7A);
    wr(8'h10, 32'h01);
    rd_chk("R3 set", 8'h08, 32'h7B);
    // R5 field readback
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R5 fields", 8'h40, 32'hC000_003F);
    // R4 routing layout: wd p0, cmp p1, tmr p2, dbg NMI, perf p3, sw0 p4, sw1 p4
    wr(8'h40, 32'h8000_0000);
    wr(8'h44, 32'h8000_0001);
    wr(8'h48, 32'h8000_0002);
    wr(8'h4C, 32'h4000_0000);
    wr(8'h50, 32'h8000_0003);
    wr(8'h54, 32'h8000_0004);
    wr(8'h58, 32'h8000_0004);
    rd_chk("R4 perf slot", 8'h50, 32'h8000_0003);
    // R2 pending order
    @(negedge clk); src = 7'h48;
    settle();
    rd_chk("R2 pending", 8'h04, 32'h48);
    // Table: R4 R6 R7
    for (int i = 0; i < 10; i++) begin
      wr(8'h0C, 32'h7F);
      wr(8'h10, {25'd0, VEC[i][13:7]});
      @(negedge clk); src = VEC[i][20:14];
      settle();
      chk($sformatf("R6 vec %0d pins", i), {26'd0, pins}, {26'd0, VEC[i][6:1]});
      chk($sformatf("R7 vec %0d nmi", i), {31'd0, nmi}, {31'd0, VEC[i][0]});
    end
    // R6 latency: source drop seen at outputs after two edges, not one
    wr(8'h10, 32'h7F);
    @(negedge clk); src = 7'h01;
    settle();
    @(negedge clk); src = 7'h00;
    @(negedge clk);
    chk("R6 still high after one edge", {26'd0, pins}, 32'h01);
    @(negedge clk);
    chk("R6 low after two edges", {26'd0, pins}, 32'h00);
    // R7 priority: debug entry with both bits and pin 2
    wr(8'h4C, 32'hC000_0002);
    @(negedge clk); src = 7'h40;
    settle();
    chk("R7 priority nmi", {31'd0, nmi}, 32'd1);
    chk("R7 priority no pin", {26'd0, pins}, 32'd0);
    // R8 out-of-range pin
    @(negedge clk); src = 7'h00;
    wr(8'h40, 32'h8000_0007);
    @(negedge clk); src = 7'h01;
    settle();
    chk("R8 pin 7 ignored", {26'd0, pins}, 32'd0);
    wr(8'h40, 32'h8000_0005);
    @(negedge clk);
    chk("R8 pin 5 used", {26'd0, pins}, 32'h20);
    // R6 pin routing off
    wr(8'h40, 32'h0000_0001);
    @(negedge clk);
    chk("R6 routing off", {26'd0, pins}, 32'd0);
    // R1 reset mid-run
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset clears pins", {26'd0, pins}, 32'd0);
    rd_chk("R1 reset clears map", 8'h40, 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule